// File: doc/BRIEF.md
# Handshaked Random Byte Fetcher

This block collects a host-chosen number of random bytes from a generator that sits on another board and runs from its own clock. For each byte it raises a request wire toward the remote side and keeps it high until the remote side answers on an acknowledge wire. It then latches the eight data pins into a holding register and hands the byte to the host through a small memory-mapped register set, with an interrupt for every byte.

The host programs a byte count to start a session. Each byte waits in the holding register until the host reads it, and no further request goes out before that read. Once the programmed number of bytes has arrived, the block stops requesting and reports the session as complete. The acknowledge wire passes through a two-flop synchronizer, and the data pins are sampled only after the synchronized acknowledge has been seen. The request/acknowledge exchange is four-phase: request rises, acknowledge rises, request falls, acknowledge falls.

Top module: `rng_byte_fetcher`

## Requirements
- R1: After reset, `link_req_o` and `host_irq` are low, the status register (address 2) reads 0 and the count register (address 0) reads 0.
- R2: Writing a nonzero count N to address 0 while idle sets the busy bit (status bit 0) and drives `link_req_o` high at the next clock edge. Reading address 0 then returns N.
- R3: `link_req_o` stays high until the synchronized acknowledge is high and then falls. It rises again only after the synchronized acknowledge has returned low.
- R4: The byte on `link_data_i` is latched when the synchronized acknowledge is seen, and a read of address 1 returns that byte.
- R5: Each latched byte sets the byte-valid bit (status bit 1) and raises `host_irq`. A read of address 1 clears both at the next edge.
- R6: While a received byte has not been read, `link_req_o` stays low and no new transfer starts.
- R7: The value read at address 0 drops by exactly one for every byte latched.
- R8: After N bytes have been received and read, `link_req_o` stays low, busy clears and the complete bit (status bit 2) is set, so status reads 4.
- R9: Writing a count of 0 starts no transfer. The complete bit is set at the next edge and `link_req_o` stays low.
- R10: A count written while busy is ignored. The remaining count and the number of bytes fetched in the session are unchanged by it.
- R11: A new nonzero count written after completion clears the complete bit and starts a fresh session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register address: 0 count, 1 data, 2 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from address |
| host_irq | output | 1 | High while a received byte waits for the host |
| link_req_o | output | 1 | Request toward the remote generator |
| link_ack_i | input | 1 | Acknowledge from the remote generator, asynchronous |
| link_data_i | input | 8 | Byte from the remote generator, asynchronous |

## Verification
The assertions check several rules on every cycle:
- the request holds until the synchronized acknowledge is seen and never rises while that acknowledge is still high;
- no request is active while a byte waits unread;
- a byte becomes valid only after a synchronized acknowledge, and the remaining count drops by one at that moment;
- completion always implies an idle link.

Only the bench scenarios can show the rest: that the byte values reach the host intact, that the session ends after exactly the programmed number of bytes, that a zero count and a write while busy behave as specified, and that the request stays low while the host delays its read. These scenarios run against a remote model with several different response delays.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  typedef enum logic [1:0] {
    LNK_IDLE = 2'd0,
    LNK_REQ  = 2'd1,
    LNK_HOLD = 2'd2
  } link_state_t;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

  localparam int ST_BUSY  = 0;
  localparam int ST_VALID = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_W     = 3;

  function automatic logic [ST_W-1:0] pack_status(input logic busy,
                                                   input logic valid,
                                                   input logic complete);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_BUSY]  = busy;
    s[ST_VALID] = valid;
    s[ST_DONE]  = complete;
    return s;
  endfunction

endpackage

// File: rtl/rbf_sync.sv
module rbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[N-2:0], d_i};
  end

  assign q_o = chain_q[N-1];
endmodule

// File: rtl/rbf_link_fsm.sv
module rbf_link_fsm
  import rbf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              ack_sync_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pending_i,
  output logic              req_o,
  output logic              busy_o,
  output logic              complete_o,
  output logic              capture_o,
  output logic [CNT_W-1:0]  remaining_o,
  output logic [DATA_W-1:0] byte_o
);

  function automatic logic [CNT_W-1:0] count_after_byte(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  link_state_t       state_q, state_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [DATA_W-1:0] byte_q;
  logic              complete_q, complete_d;
  logic              accept_load;
  logic              release_ok;

  assign accept_load = load_i && (state_q == LNK_IDLE);
  assign capture_o   = (state_q == LNK_REQ) && ack_sync_i;
  assign release_ok  = (state_q == LNK_HOLD) && !ack_sync_i && !pending_i;

  always_comb begin
    state_d    = state_q;
    remain_d   = remain_q;
    complete_d = complete_q;
    unique case (state_q)
      LNK_IDLE: begin
        if (accept_load) begin
          if (load_cnt_i == '0) begin
            complete_d = 1'b1;
          end else begin
            complete_d = 1'b0;
            remain_d   = load_cnt_i;
            state_d    = LNK_REQ;
          end
        end
      end
      LNK_REQ: begin
        if (capture_o) begin
          remain_d = count_after_byte(remain_q);
          state_d  = LNK_HOLD;
        end
      end
      LNK_HOLD: begin
        if (release_ok) begin
          if (remain_q == '0) begin
            complete_d = 1'b1;
            state_d    = LNK_IDLE;
          end else begin
            state_d = LNK_REQ;
          end
        end
      end
      default: state_d = LNK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LNK_IDLE;
      remain_q   <= '0;
      complete_q <= 1'b0;
      byte_q     <= '0;
    end else begin
      state_q    <= state_d;
      remain_q   <= remain_d;
      complete_q <= complete_d;
      if (capture_o) byte_q <= data_i;
    end
  end

  assign req_o       = (state_q == LNK_REQ);
  assign busy_o      = (state_q != LNK_IDLE);
  assign complete_o  = complete_q;
  assign remaining_o = remain_q;
  assign byte_o      = byte_q;
endmodule

// File: rtl/rbf_host_regs.sv
module rbf_host_regs
  import rbf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_cnt_o,
  output logic              pending_o,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              busy_i,
  input  logic              complete_i,
  input  logic [CNT_W-1:0]  remaining_i
);

  logic valid_q;
  logic data_read;

  assign data_read  = rd_i && (addr_i == ADDR_DATA);
  assign load_o     = wr_i && (addr_i == ADDR_COUNT);
  assign load_cnt_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (capture_i) valid_q <= 1'b1;
    else if (data_read) valid_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_COUNT: rdata_o = REG_W'(remaining_i);
      ADDR_DATA:  rdata_o = REG_W'(byte_i);
      ADDR_STAT:  rdata_o = REG_W'(pack_status(busy_i, valid_q, complete_i));
      default:    rdata_o = '0;
    endcase
  end

  assign pending_o = valid_q;
  assign irq_o     = valid_q;
endmodule

// File: rtl/rng_byte_fetcher.sv
module rng_byte_fetcher #(
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 8,
  parameter int SYNC_STGS = 2,
  localparam int REG_W    = (CNT_W > DATA_W) ? CNT_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  output logic              host_irq,
  output logic              link_req_o,
  input  logic              link_ack_i,
  input  logic [DATA_W-1:0] link_data_i
);

  logic              ack_sync;
  logic              load_evt;
  logic [CNT_W-1:0]  load_cnt;
  logic              byte_pending;
  logic              capture_evt;
  logic              busy;
  logic              complete;
  logic [CNT_W-1:0]  remaining;
  logic [DATA_W-1:0] held_byte;

  rbf_sync #(.STAGES(SYNC_STGS)) ack_sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (link_ack_i),
    .q_o  (ack_sync)
  );

  rbf_link_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) link_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .load_cnt_i (load_cnt),
    .ack_sync_i (ack_sync),
    .data_i     (link_data_i),
    .pending_i  (byte_pending),
    .req_o      (link_req_o),
    .busy_o     (busy),
    .complete_o (complete),
    .capture_o  (capture_evt),
    .remaining_o(remaining),
    .byte_o     (held_byte)
  );

  rbf_host_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .REG_W(REG_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (host_wr),
    .rd_i       (host_rd),
    .addr_i     (host_addr),
    .wdata_i    (host_wdata),
    .rdata_o    (host_rdata),
    .irq_o      (host_irq),
    .load_o     (load_evt),
    .load_cnt_o (load_cnt),
    .pending_o  (byte_pending),
    .capture_i  (capture_evt),
    .byte_i     (held_byte),
    .busy_i     (busy),
    .complete_i (complete),
    .remaining_i(remaining)
  );
endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             ack_s,
  input logic             byte_valid,
  input logic             busy,
  input logic             complete,
  input logic [CNT_W-1:0] remaining
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack_s |=> req);                                      // R3
  AST_NO_REREQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !ack_s);                                      // R3
  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !req);                                        // R6
  AST_CAPTURE_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> $past(ack_s));                         // R4
  AST_REMAIN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> remaining == CNT_W'($past(remaining) - CNT_W'(1))); // R7
  AST_COMPLETE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> !busy && !req);                                 // R8
endmodule

bind rng_byte_fetcher rbf_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (link_req_o),
  .ack_s     (ack_sync),
  .byte_valid(host_irq),
  .busy      (busy),
  .complete  (complete),
  .remaining (remaining)
);

// File: tb/rng_byte_fetcher_tb.sv
module rng_byte_fetcher_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       host_irq;
  logic       link_req_o;
  logic       link_ack_i = 1'b0;
  logic [7:0] link_data_i = 8'd0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int remote_idx = 0;
  int host_idx = 0;
  int remote_dly = 1;
  bit remote_en = 1'b1;

  // each entry: {count, remote delay}
  localparam logic [15:0] VECS [5] = '{
    {8'd1, 8'd0}, {8'd3, 8'd2}, {8'd5, 8'd5}, {8'd2, 8'd1}, {8'd4, 8'd3}
  };

  rng_byte_fetcher dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .link_req_o(link_req_o), .link_ack_i(link_ack_i),
    .link_data_i(link_data_i)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] remote_byte(input int i);
    return 8'((i * 29 + 90) & 255);
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      summary();
    end
  end

  // remote generator model, four-phase
  always begin
    @(negedge clk);
    if (remote_en && link_req_o && !link_ack_i) begin
      repeat (remote_dly) @(negedge clk);
      link_data_i = remote_byte(remote_idx);
      remote_idx++;
      link_ack_i = 1'b1;
      while (link_req_o) @(negedge clk);
      repeat (remote_dly) @(negedge clk);
      link_ack_i = 1'b0;
      link_data_i = 8'hxx ^ 8'h00;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!host_irq && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic service_bytes(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      wait_irq();
      check({tag, " R5 irq"}, host_irq, 1);
      reg_read(2'd1, d);
      check({tag, " R4 data"}, d, remote_byte(host_idx));
      host_idx++;
      check({tag, " R5 irq cleared"}, host_irq, 0);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    peek(2'd2, s);
    while (s[0] && n < 2000) begin @(negedge clk); peek(2'd2, s); n++; end
  endtask

  initial begin
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(2'd2, d); check("R1 status", d, 0);
    peek(2'd0, d); check("R1 count", d, 0);
    check("R1 req", link_req_o, 0);
    check("R1 irq", host_irq, 0);
    rst_n = 1'b1;

    // table-driven sessions
    foreach (VECS[v]) begin
      remote_dly = int'(VECS[v][7:0]);
      base = remote_idx;
      reg_write(2'd0, VECS[v][15:8]);
      check("R2 req raised", link_req_o, 1);
      peek(2'd2, d); check("R2 busy", d[0], 1);
      if (v == 0) begin
        peek(2'd0, d); check("R2 count readback", d, 1);
      end
      service_bytes(int'(VECS[v][15:8]), "vec");
      wait_idle();
      repeat (2) @(negedge clk);
      peek(2'd2, d); check("R8 status complete", d, 4);
      peek(2'd0, d); check("R8 remaining zero", d, 0);
      check("R8 req low", link_req_o, 0);
      check("R8 byte total", remote_idx - base, int'(VECS[v][15:8]));
    end
    check("R11 fresh sessions total", remote_idx, 15);

    // R6 and R7: host delays its read
    remote_dly = 1;
    base = remote_idx;
    reg_write(2'd0, 8'd3);
    wait_irq();
    peek(2'd0, d); check("R7 remaining after one", d, 2);
    peek(2'd2, d); check("R11 complete cleared", d[2], 0);
    check("R5 status valid bit", d[1], 1);
    repeat (20) @(negedge clk);
    check("R6 req held low", link_req_o, 0);
    check("R6 no extra request", remote_idx - base, 1);
    service_bytes(1, "r6");
    wait_irq();
    peek(2'd0, d); check("R7 remaining after two", d, 1);
    service_bytes(2, "r6");
    wait_idle();

    // R3: request persists while remote stays silent
    remote_en = 1'b0;
    base = remote_idx;
    reg_write(2'd0, 8'd3);
    repeat (30) @(negedge clk);
    check("R3 req held", link_req_o, 1);
    // R10: write while busy ignored
    reg_write(2'd0, 8'd9);
    peek(2'd0, d); check("R10 remaining kept", d, 3);
    remote_en = 1'b1;
    service_bytes(3, "r10");
    wait_idle();
    repeat (30) @(negedge clk);
    check("R10 byte total", remote_idx - base, 3);
    peek(2'd2, d); check("R10 complete", d, 4);

    // R9: zero count
    base = remote_idx;
    reg_write(2'd0, 8'd5);
    service_bytes(5, "pre");
    wait_idle();
    reg_write(2'd0, 8'd0);
    peek(2'd2, d); check("R9 complete at once", d, 4);
    repeat (10) @(negedge clk);
    check("R9 req low", link_req_o, 0);
    check("R9 no transfer", remote_idx - base, 5);

    summary();
  end
endmodule